// File: doc/BRIEF.md
# Exception Entry and Vector Generator

This block computes the full architectural state change that a processor core makes when it takes an exception. The core presents one request per cycle with the following information:

- the kind of exception;
- for address translation faults, the fault class, the access kind and the faulting virtual address;
- the current PC, together with its delay-slot, 16-bit-branch and compact-ISA flags;
- the status bits EXL, ERL and BEV;
- the exception base, the interrupt vector spacing, and the pending and mask interrupt lines;
- the present values of the context and entry-hi registers.

One clock later, the block presents in a single registered bundle:

- the handler PC;
- the return PC, with write enables for the exception PC and the error PC;
- the branch-delay bit;
- the 5-bit exception code;
- the new EXL, ERL and BEV bits;
- for translation faults, the new bad-address, context and entry-hi values.

The core applies every write enable that is high in that cycle and does nothing in any other cycle. The block holds no architectural state of its own. As a result, nested exceptions, where EXL is already set, depend only on the status bits that the core feeds back.

Top module: `exc_entry`

## Requirements
- R1: For `req_kind`=1 (translation fault), `fault_kind` selects the code. A value of 0 (bad address) gives 5 when `acc_kind`=1 (store) and 4 for load (0) or fetch (2). A value of 1 (no match) or 2 (invalid) gives 3 for a store and 2 otherwise. A value of 3 (dirty) gives 1. A value of 4 (read inhibit) gives 19, and 5 (execute inhibit) gives 20, while `sep_inh_en` is high; both give 2 while it is low.
- R2: For a translation fault, `vaddr_we` is high and `badvaddr` equals the fault address. `new_context` keeps bits 31:23 of `cur_context`, takes address bits 31:13 in bits 22:4, and has bits 3:0 zero. `new_entryhi` takes address bits 31:13, has bits 12:8 zero, and keeps bits 7:0 of `cur_entryhi`. For every other kind, `vaddr_we` is low.
- R3: `req_kind` values 0, 2, 3, 4, 5, 6, 7, 8 and 9 (interrupt, instruction bus, data bus, syscall, break, reserved instruction, coprocessor unusable, overflow, trap) give codes 0, 6, 7, 8, 9, 10, 11, 12 and 13, with `cause_we` high.
- R4: Non-interrupt exceptions use offset 0x180. The exception is a no-match translation fault with EXL clear uses offset 0x000. A no-match with EXL set uses 0x180.
- R5: Interrupts use offset 0x200 when `vec_int_en` is low, when BEV is set, or when `int_spacing` is 0. Otherwise the offset is 0x200 + v × (`int_spacing` × 32). Here v is the index of the highest set bit of `irq_pending` & `irq_mask`, and v is 0 when none is set.
- R6: The handler PC is base + offset. The base is 0xBFC00200 when BEV is set, and otherwise `ebase` with bits 9:0 cleared.
- R7: For a non-NMI request with EXL clear, `epc_we` and `bd_we` are high, and `bd_val` equals the delay-slot flag. With EXL set, both write enables are low. `new_exl` is 1 for every non-NMI request.
- R8: The return PC is `cur_pc` with bit 0 ORed with `compact_mode`. When `in_dslot` is high, 4 is subtracted from it, or 2 when `br16` is also high.
- R9: For an NMI (`req_kind`=10), the handler PC is 0xBFC00000. `errepc_we`, `new_erl` and `new_bev` are high, `epc_we`, `bd_we` and `cause_we` are low, and `new_exl` equals the incoming EXL.
- R10: `upd_valid` rises exactly one cycle after `req_valid`. In every cycle where `upd_valid` is low, all write enables are low. After reset, `upd_valid` and all write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Exception request this cycle |
| req_kind | input | 4 | Exception kind (see R1, R3, R9) |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch |
| fault_kind | input | 3 | Translation fault class (see R1) |
| fault_addr | input | 32 | Faulting virtual address |
| cur_pc | input | 32 | PC of the excepting instruction |
| in_dslot | input | 1 | Instruction sits in a branch delay slot |
| br16 | input | 1 | The branch owning the slot is 16 bits |
| compact_mode | input | 1 | Compact ISA active |
| stat_exl | input | 1 | Current EXL |
| stat_erl | input | 1 | Current ERL |
| stat_bev | input | 1 | Current BEV |
| sep_inh_en | input | 1 | Separate inhibit codes enabled |
| vec_int_en | input | 1 | Vectored interrupts enabled |
| ebase | input | 32 | Exception base register |
| int_spacing | input | 5 | Vector spacing in 32-byte units |
| irq_pending | input | 8 | Pending interrupt lines |
| irq_mask | input | 8 | Interrupt mask bits |
| cur_context | input | 32 | Present context register |
| cur_entryhi | input | 32 | Present entry-hi register |
| upd_valid | output | 1 | Update bundle valid |
| new_pc | output | 32 | Handler PC |
| ret_pc | output | 32 | Return PC for EPC or ErrorEPC |
| epc_we | output | 1 | Write EPC |
| errepc_we | output | 1 | Write ErrorEPC |
| bd_we | output | 1 | Write branch-delay bit |
| bd_val | output | 1 | Branch-delay bit value |
| cause_we | output | 1 | Write exception code |
| cause_code | output | 5 | Exception code |
| new_exl | output | 1 | New EXL |
| new_erl | output | 1 | New ERL |
| new_bev | output | 1 | New BEV |
| vaddr_we | output | 1 | Write bad-address, context, entry-hi |
| badvaddr | output | 32 | New bad-address value |
| new_context | output | 32 | New context value |
| new_entryhi | output | 32 | New entry-hi value |

## Verification
Every output field is registered from a single request. A wrong decode or a stale pipeline register therefore appears at the ports in the cycle right after the request, either as a wrong code or handler address, or as a write enable that is high when it should be low. An error in the interrupt priority encoder shows only under vectored mode with several lines pending. An error in the EXL freeze shows only on nested requests. For this reason the stimulus drives both cases on purpose. An enable that lingers into an idle cycle is caught on that idle cycle, because outputs are compared on every clock.

// File: rtl/exc_pkg.sv
// Package: shared constants and kind encodings for exception entry.
// Assumes a 32-bit address space and 8 interrupt lines.
package exc_pkg;
    localparam int XLEN        = 32;
    localparam int CODE_W      = 5;
    localparam int N_IRQ       = 8;
    localparam int ASID_W      = 8;
    localparam int VPN2_LSB    = 13;
    localparam int EBASE_LSB   = 10;
    localparam int CTX_VPN_LSB = 4;
    localparam int CTX_KEEP_LSB = CTX_VPN_LSB + (XLEN - VPN2_LSB);

    localparam logic [XLEN-1:0] BOOT_BASE  = 32'hBFC0_0200;
    localparam logic [XLEN-1:0] NMI_VECTOR = 32'hBFC0_0000;
    localparam logic [XLEN-1:0] OFF_GEN    = 32'h0000_0180;
    localparam logic [XLEN-1:0] OFF_REFILL = 32'h0000_0000;
    localparam logic [XLEN-1:0] OFF_INT    = 32'h0000_0200;

    typedef enum logic [3:0] {
        EK_INT  = 4'd0,  EK_XLAT = 4'd1,  EK_IBUS = 4'd2, EK_DBUS = 4'd3,
        EK_SYSC = 4'd4,  EK_BRK  = 4'd5,  EK_RSVD = 4'd6, EK_COPU = 4'd7,
        EK_OVF  = 4'd8,  EK_TRAP = 4'd9,  EK_NMI  = 4'd10
    } exc_kind_e;

    typedef enum logic [1:0] {
        AK_LOAD = 2'd0, AK_STORE = 2'd1, AK_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [2:0] {
        XF_BADADDR = 3'd0, XF_NOMATCH = 3'd1, XF_INVALID = 3'd2,
        XF_DIRTY   = 3'd3, XF_RDINH   = 3'd4, XF_EXINH   = 3'd5
    } xlat_fault_e;
endpackage

// File: rtl/exc_code_map.sv
// Module: exc_code_map
// Maps the exception kind (and for translation faults the fault class and
// access kind) to a 5-bit exception code. Flags TLB refill cases and
// whether the cause field is written (all kinds but NMI).
// Assumes undefined fault classes behave as a bad address.
module exc_code_map
    import exc_pkg::*;
(
    input  exc_kind_e               kind,
    input  acc_kind_e               acc,
    input  xlat_fault_e             fault,
    input  logic                    sep_en,
    output logic [CODE_W-1:0]       code,
    output logic                    cause_we,
    output logic                    refill
);
    logic is_store;
    assign is_store = (acc == AK_STORE);

    // Code selection per kind and fault class.
    always_comb begin
        code = '0;
        unique case (kind)
            EK_INT:  code = CODE_W'(0);
            EK_XLAT: begin
                case (fault)
                    XF_NOMATCH, XF_INVALID: code = is_store ? CODE_W'(3) : CODE_W'(2);
                    XF_DIRTY:               code = CODE_W'(1);
                    XF_RDINH:               code = sep_en ? CODE_W'(19) : CODE_W'(2);
                    XF_EXINH:               code = sep_en ? CODE_W'(20) : CODE_W'(2);
                    default:                code = is_store ? CODE_W'(5) : CODE_W'(4);
                endcase
            end
            EK_IBUS: code = CODE_W'(6);
            EK_DBUS: code = CODE_W'(7);
            EK_SYSC: code = CODE_W'(8);
            EK_BRK:  code = CODE_W'(9);
            EK_RSVD: code = CODE_W'(10);
            EK_COPU: code = CODE_W'(11);
            EK_OVF:  code = CODE_W'(12);
            EK_TRAP: code = CODE_W'(13);
            default: code = '0;
        endcase
    end

    // NMI leaves the cause field alone; refill marks a no-match translation.
    assign cause_we = (kind != EK_NMI);
    assign refill   = (kind == EK_XLAT) && (fault == XF_NOMATCH);
endmodule

// File: rtl/exc_vector_gen.sv
// Module: exc_vector_gen
// Produces the handler PC: base (boot or exception base) plus an offset
// chosen by kind, refill/EXL and the interrupt vectoring controls. The
// highest-numbered enabled pending line wins. NMI has a fixed vector.
module exc_vector_gen
    import exc_pkg::*;
#(
    parameter int LINES = N_IRQ
) (
    input  exc_kind_e               kind,
    input  logic                    refill,
    input  logic                    exl,
    input  logic                    bev,
    input  logic                    vec_en,
    input  logic [4:0]              spacing,
    input  logic [LINES-1:0]        pending,
    input  logic [LINES-1:0]        mask,
    input  logic [XLEN-1:0]         ebase,
    output logic [XLEN-1:0]         handler_pc
);
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam logic [XLEN-1:0] EBASE_MASK = ~((XLEN'(1) << EBASE_LSB) - XLEN'(1));

    logic [LINES-1:0] active;
    logic [IDX_W-1:0] top_idx;
    logic [XLEN-1:0]  step, offset, base;

    assign active = pending & mask;

    // Priority encoder: later (higher) lines override earlier ones.
    always_comb begin
        top_idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (active[i]) top_idx = IDX_W'(i);
        end
    end

    assign step = XLEN'({spacing, 5'b00000});

    // Offset selection by exception kind and controls.
    always_comb begin
        if (kind == EK_INT) begin
            if (!vec_en || bev || (spacing == 5'd0))
                offset = OFF_INT;
            else
                offset = OFF_INT + XLEN'(top_idx) * step;
        end else if (refill && !exl) begin
            offset = OFF_REFILL;
        end else begin
            offset = OFF_GEN;
        end
    end

    assign base       = bev ? BOOT_BASE : (ebase & EBASE_MASK);
    assign handler_pc = (kind == EK_NMI) ? NMI_VECTOR : (base + offset);
endmodule

// File: rtl/exc_capture.sv
// Module: exc_capture
// Computes the return PC with delay-slot correction and the new context
// and entry-hi values derived from a faulting address.
module exc_capture
    import exc_pkg::*;
(
    input  logic [XLEN-1:0]  pc,
    input  logic             compact,
    input  logic             dslot,
    input  logic             br16,
    input  logic [XLEN-1:0]  addr,
    input  logic [XLEN-1:0]  ctx_in,
    input  logic [XLEN-1:0]  ehi_in,
    output logic [XLEN-1:0]  ret_pc,
    output logic [XLEN-1:0]  ctx_out,
    output logic [XLEN-1:0]  ehi_out
);
    localparam logic [XLEN-1:0] CTX_KEEP = ~((XLEN'(1) << CTX_KEEP_LSB) - XLEN'(1));
    localparam logic [XLEN-1:0] VPN2_MSK = ~((XLEN'(1) << VPN2_LSB) - XLEN'(1));
    localparam logic [XLEN-1:0] ASID_MSK = (XLEN'(1) << ASID_W) - XLEN'(1);

    logic [XLEN-1:0] tagged_pc, back_step;

    // Return address: mode tag in bit 0, step back over the branch if in a slot.
    assign tagged_pc = pc | XLEN'(compact);
    assign back_step = !dslot ? '0 : (br16 ? XLEN'(2) : XLEN'(4));
    assign ret_pc    = tagged_pc - back_step;

    // Context and entry-hi merge of address page bits with preserved fields.
    assign ctx_out = (ctx_in & CTX_KEEP) | ((addr & VPN2_MSK) >> (VPN2_LSB - CTX_VPN_LSB));
    assign ehi_out = (ehi_in & ASID_MSK) | (addr & VPN2_MSK);
endmodule

// File: rtl/exc_entry.sv
// Module: exc_entry (top)
// Registers one complete exception-entry update bundle one cycle after a
// request. Write enables are high only in the valid cycle; data fields hold
// their last value otherwise. Assumes the caller applies the bundle at once.
module exc_entry
    import exc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [3:0]           req_kind,
    input  logic [1:0]           acc_kind,
    input  logic [2:0]           fault_kind,
    input  logic [31:0]          fault_addr,
    input  logic [31:0]          cur_pc,
    input  logic                 in_dslot,
    input  logic                 br16,
    input  logic                 compact_mode,
    input  logic                 stat_exl,
    input  logic                 stat_erl,
    input  logic                 stat_bev,
    input  logic                 sep_inh_en,
    input  logic                 vec_int_en,
    input  logic [31:0]          ebase,
    input  logic [4:0]           int_spacing,
    input  logic [7:0]           irq_pending,
    input  logic [7:0]           irq_mask,
    input  logic [31:0]          cur_context,
    input  logic [31:0]          cur_entryhi,
    output logic                 upd_valid,
    output logic [31:0]          new_pc,
    output logic [31:0]          ret_pc,
    output logic                 epc_we,
    output logic                 errepc_we,
    output logic                 bd_we,
    output logic                 bd_val,
    output logic                 cause_we,
    output logic [4:0]           cause_code,
    output logic                 new_exl,
    output logic                 new_erl,
    output logic                 new_bev,
    output logic                 vaddr_we,
    output logic [31:0]          badvaddr,
    output logic [31:0]          new_context,
    output logic [31:0]          new_entryhi
);
    exc_kind_e          kind;
    logic               is_nmi, is_xlat;
    logic [CODE_W-1:0]  code_c;
    logic               cause_we_c, refill_c;
    logic [XLEN-1:0]    hpc_c, rpc_c, ctx_c, ehi_c;

    assign kind    = exc_kind_e'(req_kind);
    assign is_nmi  = (kind == EK_NMI);
    assign is_xlat = (kind == EK_XLAT);

    exc_code_map u_code (
        .kind     (kind),
        .acc      (acc_kind_e'(acc_kind)),
        .fault    (xlat_fault_e'(fault_kind)),
        .sep_en   (sep_inh_en),
        .code     (code_c),
        .cause_we (cause_we_c),
        .refill   (refill_c)
    );

    exc_vector_gen #(.LINES(N_IRQ)) u_vec (
        .kind       (kind),
        .refill     (refill_c),
        .exl        (stat_exl),
        .bev        (stat_bev),
        .vec_en     (vec_int_en),
        .spacing    (int_spacing),
        .pending    (irq_pending),
        .mask       (irq_mask),
        .ebase      (ebase),
        .handler_pc (hpc_c)
    );

    exc_capture u_cap (
        .pc      (cur_pc),
        .compact (compact_mode),
        .dslot   (in_dslot),
        .br16    (br16),
        .addr    (fault_addr),
        .ctx_in  (cur_context),
        .ehi_in  (cur_entryhi),
        .ret_pc  (rpc_c),
        .ctx_out (ctx_c),
        .ehi_out (ehi_c)
    );

    // Strobes: valid and write enables, live only in the cycle after a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            epc_we    <= 1'b0;
            errepc_we <= 1'b0;
            bd_we     <= 1'b0;
            cause_we  <= 1'b0;
            vaddr_we  <= 1'b0;
        end else begin
            upd_valid <= req_valid;
            epc_we    <= req_valid && !is_nmi && !stat_exl;
            bd_we     <= req_valid && !is_nmi && !stat_exl;
            errepc_we <= req_valid && is_nmi;
            cause_we  <= req_valid && cause_we_c;
            vaddr_we  <= req_valid && is_xlat;
        end
    end

    // Data bundle: captured on an accepted request, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_pc      <= '0;
            ret_pc      <= '0;
            bd_val      <= 1'b0;
            cause_code  <= '0;
            new_exl     <= 1'b0;
            new_erl     <= 1'b0;
            new_bev     <= 1'b0;
            badvaddr    <= '0;
            new_context <= '0;
            new_entryhi <= '0;
        end else if (req_valid) begin
            new_pc      <= hpc_c;
            ret_pc      <= rpc_c;
            bd_val      <= in_dslot;
            cause_code  <= code_c;
            new_exl     <= is_nmi ? stat_exl : 1'b1;
            new_erl     <= is_nmi ? 1'b1 : stat_erl;
            new_bev     <= is_nmi ? 1'b1 : stat_bev;
            badvaddr    <= fault_addr;
            new_context <= ctx_c;
            new_entryhi <= ehi_c;
        end
    end
endmodule

// File: rtl/exc_entry_chk.sv
// Module: exc_entry_chk
// Temporal checks on the exception-entry bundle, bound to exc_entry.
module exc_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [3:0]  req_kind,
    input logic        stat_exl,
    input logic        upd_valid,
    input logic [31:0] new_pc,
    input logic        epc_we,
    input logic        errepc_we,
    input logic        bd_we,
    input logic        cause_we,
    input logic        new_exl,
    input logic        new_erl,
    input logic        new_bev,
    input logic        vaddr_we,
    input logic [31:0] badvaddr,
    input logic [31:0] new_entryhi
);
    logic seen;

    // Marks that at least one cycle has passed since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    p_valid_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (upd_valid == $past(req_valid)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> !(epc_we || errepc_we || bd_we || cause_we || vaddr_we));

    p_epc_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(req_valid) && $past(stat_exl)) |-> (!epc_we && !bd_we));

    p_exl_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !errepc_we) |-> new_exl);

    p_save_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(epc_we && errepc_we));

    p_nmi_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(req_valid) && ($past(req_kind) == 4'd10)) |->
        (errepc_we && new_erl && new_bev && !cause_we && new_pc == 32'hBFC0_0000));

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vaddr_we |-> (new_entryhi[31:13] == badvaddr[31:13]));
endmodule

bind exc_entry exc_entry_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .stat_exl    (stat_exl),
    .upd_valid   (upd_valid),
    .new_pc      (new_pc),
    .epc_we      (epc_we),
    .errepc_we   (errepc_we),
    .bd_we       (bd_we),
    .cause_we    (cause_we),
    .new_exl     (new_exl),
    .new_erl     (new_erl),
    .new_bev     (new_bev),
    .vaddr_we    (vaddr_we),
    .badvaddr    (badvaddr),
    .new_entryhi (new_entryhi)
);

// File: tb/exc_entry_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model, queue of expected bundles, compared
// at every falling edge.
module exc_entry_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req_valid, in_dslot, br16, compact_mode, stat_exl, stat_erl, stat_bev;
    logic        sep_inh_en, vec_int_en;
    logic [3:0]  req_kind;
    logic [1:0]  acc_kind;
    logic [2:0]  fault_kind;
    logic [31:0] fault_addr, cur_pc, ebase, cur_context, cur_entryhi;
    logic [4:0]  int_spacing;
    logic [7:0]  irq_pending, irq_mask;

    logic        upd_valid, epc_we, errepc_we, bd_we, bd_val, cause_we;
    logic        new_exl, new_erl, new_bev, vaddr_we;
    logic [4:0]  cause_code;
    logic [31:0] new_pc, ret_pc, badvaddr, new_context, new_entryhi;

    exc_entry dut_i (.*);

    typedef struct {
        bit valid; bit epc_we; bit errepc_we; bit bd_we; bit bd_val; bit cause_we;
        bit exl; bit erl; bit bev; bit vaddr_we;
        int code; logic [31:0] pc; logic [31:0] ret; logic [31:0] badv;
        logic [31:0] ctx; logic [31:0] ehi; string tag;
    } exp_t;

    exp_t exp_q[$];
    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(string tag);
        exp_t e;
        int off, v;
        logic [31:0] base, pm;
        bit st;
        e = '{default: 0};
        e.tag = tag;
        e.valid = req_valid;
        if (!req_valid) return e;
        st = (acc_kind == 2'd1);
        case (req_kind)
            4'd0: e.code = 0;
            4'd1: case (fault_kind)
                      3'd1, 3'd2: e.code = st ? 3 : 2;
                      3'd3: e.code = 1;
                      3'd4: e.code = sep_inh_en ? 19 : 2;
                      3'd5: e.code = sep_inh_en ? 20 : 2;
                      default: e.code = st ? 5 : 4;
                  endcase
            default: e.code = (req_kind <= 4'd9) ? int'(req_kind) + 4 : 0;
        endcase
        if (req_kind == 4'd0) begin
            if (!vec_int_en || stat_bev || int_spacing == 0) off = 'h200;
            else begin
                pm = {24'h0, irq_pending & irq_mask};
                v = 0;
                for (int i = 7; i >= 0; i--) if (pm[i]) begin v = i; break; end
                off = 'h200 + v * int'(int_spacing) * 32;
            end
        end else if (req_kind == 4'd1 && fault_kind == 3'd1 && !stat_exl) off = 0;
        else off = 'h180;
        base = stat_bev ? 32'hBFC00200 : {ebase[31:10], 10'h0};
        e.ret = {cur_pc[31:1], cur_pc[0] | compact_mode};
        if (in_dslot) e.ret = e.ret - (br16 ? 2 : 4);
        if (req_kind == 4'd10) begin
            e.pc = 32'hBFC00000; e.errepc_we = 1; e.erl = 1; e.bev = 1; e.exl = stat_exl;
        end else begin
            e.pc = base + off; e.cause_we = 1; e.exl = 1; e.erl = stat_erl; e.bev = stat_bev;
            e.epc_we = !stat_exl; e.bd_we = !stat_exl; e.bd_val = in_dslot;
        end
        if (req_kind == 4'd1) begin
            e.vaddr_we = 1;
            e.badv = fault_addr;
            e.ctx  = {cur_context[31:23], fault_addr[31:13], 4'h0};
            e.ehi  = {fault_addr[31:13], 5'h0, cur_entryhi[7:0]};
        end
        return e;
    endfunction

    task automatic compare(exp_t e);
        chk(e.valid ? e.tag : "R10", "upd_valid", 32'(upd_valid), 32'(e.valid));
        chk("R7", "epc_we", 32'(epc_we), 32'(e.epc_we));
        chk("R7", "bd_we", 32'(bd_we), 32'(e.bd_we));
        chk("R9", "errepc_we", 32'(errepc_we), 32'(e.errepc_we));
        chk(e.tag, "cause_we", 32'(cause_we), 32'(e.cause_we));
        chk("R2", "vaddr_we", 32'(vaddr_we), 32'(e.vaddr_we));
        if (e.valid) begin
            chk(e.tag, "new_pc", new_pc, e.pc);
            chk("R8", "ret_pc", ret_pc, e.ret);
            chk("R7", "new_exl", 32'(new_exl), 32'(e.exl));
            chk("R9", "new_erl", 32'(new_erl), 32'(e.erl));
            chk("R9", "new_bev", 32'(new_bev), 32'(e.bev));
            if (e.bd_we) chk("R7", "bd_val", 32'(bd_val), 32'(e.bd_val));
            if (e.cause_we) chk(e.tag, "cause_code", 32'(cause_code), 32'(e.code));
            if (e.vaddr_we) begin
                chk("R2", "badvaddr", badvaddr, e.badv);
                chk("R2", "new_context", new_context, e.ctx);
                chk("R2", "new_entryhi", new_entryhi, e.ehi);
            end
        end
    endtask

    // One cycle: record expectation for present inputs, compare after the edge.
    task automatic tick(string tag);
        exp_q.push_back(model(tag));
        @(negedge clk);
        compare(exp_q.pop_front());
        req_valid = 1'b0;
    endtask

    task automatic idle_in();
        req_valid = 0; req_kind = 0; acc_kind = 0; fault_kind = 0;
        fault_addr = 32'h1234_5678; cur_pc = 32'h8000_1000;
        in_dslot = 0; br16 = 0; compact_mode = 0;
        stat_exl = 0; stat_erl = 0; stat_bev = 0; sep_inh_en = 0; vec_int_en = 0;
        ebase = 32'h8000_0000; int_spacing = 0; irq_pending = 0; irq_mask = 0;
        cur_context = 32'hFFFF_FFFF; cur_entryhi = 32'hFFFF_FFA5;
    endtask

    task automatic fire(logic [3:0] k, string tag);
        req_valid = 1'b1; req_kind = k;
        tick(tag);
        tick(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle_in();
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "reset upd_valid", 32'(upd_valid), 0);
        chk("R10", "reset epc_we", 32'(epc_we), 0);
        chk("R10", "reset vaddr_we", 32'(vaddr_we), 0);
        rst_n = 1'b1;
        tick("R10");

        // R1/R2: translation faults, loads and stores, base from ebase
        fault_kind = 3'd0; acc_kind = 2'd0; fault_addr = 32'h7654_3210; fire(4'd1, "R1");
        acc_kind = 2'd1; fire(4'd1, "R1");
        acc_kind = 2'd2; fault_addr = 32'hC000_2FFF; fire(4'd1, "R1");
        fault_kind = 3'd2; acc_kind = 2'd1; fire(4'd1, "R1");
        fault_kind = 3'd3; fire(4'd1, "R1");
        fault_kind = 3'd4; acc_kind = 2'd0; sep_inh_en = 1; fire(4'd1, "R1");
        fault_kind = 3'd5; acc_kind = 2'd2; fire(4'd1, "R1");
        sep_inh_en = 0; fire(4'd1, "R1");
        fault_kind = 3'd4; fire(4'd1, "R1");
        // R4: refill offset with EXL clear vs set; R6 base
        fault_kind = 3'd1; acc_kind = 2'd0; ebase = 32'h8000_1234; fire(4'd1, "R4");
        acc_kind = 2'd1; stat_exl = 1; cur_context = 32'h0; cur_entryhi = 32'h0000_1F3C;
        fire(4'd1, "R4");
        stat_exl = 0; stat_bev = 1; fire(4'd1, "R6");
        stat_bev = 0;
        // R3: fixed codes
        for (int k = 2; k <= 9; k++) fire(4'(k), "R3");
        // R5: interrupts
        fire(4'd0, "R5");
        vec_int_en = 1; int_spacing = 5'd1; irq_pending = 8'h24; irq_mask = 8'hFF;
        fire(4'd0, "R5");
        irq_mask = 8'h0F; int_spacing = 5'd3; fire(4'd0, "R5");
        irq_pending = 8'hFF; irq_mask = 8'h80; int_spacing = 5'd31; fire(4'd0, "R5");
        irq_mask = 8'h00; fire(4'd0, "R5");
        irq_mask = 8'hFF; int_spacing = 5'd0; fire(4'd0, "R5");
        int_spacing = 5'd2; stat_bev = 1; fire(4'd0, "R5");
        stat_bev = 0; vec_int_en = 0;
        // R7/R8: delay slot and return PC
        in_dslot = 1; cur_pc = 32'h0040_0010; fire(4'd4, "R8");
        br16 = 1; compact_mode = 1; fire(4'd4, "R8");
        in_dslot = 0; fire(4'd5, "R8");
        in_dslot = 1; stat_exl = 1; fire(4'd6, "R7");
        stat_exl = 0; br16 = 0; compact_mode = 0;
        // R9: NMI with EXL clear and set
        stat_erl = 0; fire(4'd10, "R9");
        stat_exl = 1; fire(4'd10, "R9");
        stat_exl = 0; in_dslot = 0;
        // R10: back-to-back requests
        req_valid = 1; req_kind = 4'd8; tick("R10");
        req_valid = 1; req_kind = 4'd1; fault_kind = 3'd3; tick("R10");
        req_valid = 1; req_kind = 4'd10; tick("R10");
        tick("R10");
        tick("R10");
        finish_run();
    end
endmodule